// File: doc/BRIEF.md
# E1 Receive Alarm Event Latch

This block sits behind an E1 receive framer and turns its per-frame and per-word qualifier pulses into a sticky 8-bit event word. It watches five things. The first is error runs on frame alignment words and on CAS multiframe alignment words. The second is the density of CRC-4 codeword errors over fixed blocks. The third is the zero content of time slot 16. The fourth is multiframe boundaries. The fifth is the every-other-frame point at which the international and national spare bits can be read.

Each condition raises its own status bit for one cycle. The bit then stays set until it is written off with a write-one-to-clear strobe. The four low bits can each raise the interrupt output through their own enable bits.

All inputs are single-cycle strobes with qualifiers, sampled on the rising clock edge. A bit set at an edge is visible on `status` in the cycle after the strobe. Frame alignment search, CRC calculation and line decoding are done elsewhere.

Top module: `e1_rx_event_latch`

## Requirements
- R1: After a synchronous active-high reset, `status` is 8'h00 and `irq` is 0.
- R2: Bit 4 sets when a third errored frame alignment word (`fas_stb` with `fas_bad`=1) follows two errored ones without a good word in between. A good word restarts the run, and the run also restarts after each event.
- R3: Bit 5 sets on the second errored CAS multiframe alignment word in a row (`cas_stb` with `cas_bad`=1). A good word restarts the run, and the run also restarts after each event.
- R4: CRC-4 codewords (`crc_stb`) are grouped into back-to-back blocks of 1000, counted from reset. Bit 6 sets on the last codeword of a block if at least 915 of that block's codewords had `crc_bad`=1. A block with 914 errors does not set it.
- R5: Frames (`frame_stb`) are grouped into back-to-back blocks of 16, counted from reset. Bit 3 sets on the 16th frame of a block if the `ts16_byte` values of those 16 frames hold fewer than three zero bits in total. No mode input disables this check.
- R6: Bit 2 sets when a frame flagged `sig_mf_first`=1 and the 15 frames that follow it all carry `ts16_byte`=8'h00. A non-zero byte ends the run. A run that does not begin at a flagged frame never sets the bit.
- R7: With `crc4_en`=1, bit 1 sets on each `crc_mf_stb` pulse. With `crc4_en`=0, `crc_mf_stb` is ignored and bit 1 sets instead on the 16th frame of each 16-frame block of R5.
- R8: Bit 0 sets on every second frame strobe after reset (the 2nd, 4th, 6th and so on).
- R9: When `clr_we`=1, each status bit whose `clr_bits` bit is 1 is cleared. An event in the same cycle wins over the clear. Bit 7 always reads 0.
- R10: `irq` is 1 exactly when some bit k in 0..3 has both `status[k]`=1 and `irq_en[k]`=1. Bits 4 to 6 never drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame; qualifies `ts16_byte` and `sig_mf_first` |
| ts16_byte | input | 8 | Time slot 16 content of the current frame |
| sig_mf_first | input | 1 | Current frame is frame 0 of the signalling multiframe |
| crc_mf_stb | input | 1 | CRC-4 multiframe boundary pulse |
| fas_stb | input | 1 | A frame alignment word was checked |
| fas_bad | input | 1 | That frame alignment word was in error |
| cas_stb | input | 1 | A CAS multiframe alignment word was checked |
| cas_bad | input | 1 | That CAS word was in error |
| crc_stb | input | 1 | A CRC-4 codeword was checked |
| crc_bad | input | 1 | That codeword was in error |
| crc4_en | input | 1 | CRC-4 multiframing in use |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | 8 | Bits to clear |
| irq_en | input | 4 | Interrupt enables for status bits 0..3 |
| status | output | 8 | Sticky event word |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the exact block edges. It sends 914 versus 915 errored codewords, and two versus three zero bits in a 16-frame block. A window that is off by one codeword or one frame, or a `<=` used where `<` belongs, would flip one of these results. Error runs are broken by a single good word, so a counter that saturates or is never cleared would raise bit 4 or bit 5 too early. A clear that lands in the same cycle as an event must leave the bit set; a latch that gives the clear priority would lose the event. The bench also toggles `crc4_en` to show that frame-derived multiframe marks appear only when it is 0 and that `crc_mf_stb` pulses count only when it is 1.

// File: rtl/e1_evt_pkg.sv
package e1_evt_pkg;

    localparam int STATUS_W = 8;
    localparam int IRQ_SRC  = 4;

    typedef struct packed {
        logic crc_resync;
        logic cas_resync;
        logic fas_resync;
        logic sig_ones;
        logic sig_zeros;
        logic mf_mark;
        logic align_mark;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

    function automatic logic [3:0] zero_bits(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            if (!b[i]) n = n + 4'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/e1_err_run.sv
module e1_err_run #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_i,
    input  logic bad_i,
    output logic evt_o
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

    logic [RW-1:0] run_q;

    assign evt_o = stb_i && bad_i && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (stb_i) begin
            if (!bad_i || run_q == LAST) run_q <= '0;
            else                         run_q <= run_q + RW'(1);
        end
    end

    // R2 / R3: a good word restarts the run
    a_r2_r3_good_word_clears: assert property (@(posedge clk) disable iff (rst)
        (stb_i && !bad_i) |=> (run_q == '0));

endmodule

// File: rtl/e1_crc_window.sv
module e1_crc_window #(
    parameter int BLOCK  = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_i,
    input  logic bad_i,
    output logic evt_o
);
    localparam int IW = $clog2(BLOCK);
    localparam int EW = $clog2(BLOCK + 1);
    localparam logic [IW-1:0] LAST = IW'(BLOCK - 1);

    logic [IW-1:0] idx_q;
    logic [EW-1:0] errs_q;
    logic [EW-1:0] errs_nx;
    logic          last;

    assign last    = (idx_q == LAST);
    assign errs_nx = errs_q + EW'(bad_i);
    assign evt_o   = stb_i && last && (errs_nx >= EW'(THRESH));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            errs_q <= '0;
        end else if (stb_i) begin
            if (last) begin
                idx_q  <= '0;
                errs_q <= '0;
            end else begin
                idx_q  <= idx_q + IW'(1);
                errs_q <= errs_nx;
            end
        end
    end

    // R4: the codeword index wraps after the last codeword of a block
    a_r4_block_wraps: assert property (@(posedge clk) disable iff (rst)
        (stb_i && last) |=> (idx_q == '0 && errs_q == '0));

endmodule

// File: rtl/e1_frame_timing.sv
module e1_frame_timing
    import e1_evt_pkg::*;
#(
    parameter int SIG_FRAMES = 16,
    parameter int ONES_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic [7:0] ts16,
    input  logic       crc4_en,
    input  logic       crc_mf_stb,
    output logic       align_o,
    output logic       mf_o,
    output logic       ones_o
);
    localparam int CW = $clog2(SIG_FRAMES);
    localparam int ZW = $clog2(SIG_FRAMES * 8 + 1);
    localparam logic [CW-1:0] LAST = CW'(SIG_FRAMES - 1);

    logic [CW-1:0] fcnt_q;
    logic [ZW-1:0] zacc_q;
    logic [ZW-1:0] ztot;
    logic          par_q;
    logic          blk_end;

    assign blk_end = frame_stb && (fcnt_q == LAST);
    assign ztot    = zacc_q + ZW'(zero_bits(ts16));
    assign align_o = frame_stb && par_q;
    assign ones_o  = blk_end && (ztot < ZW'(ONES_LIMIT));
    assign mf_o    = crc4_en ? crc_mf_stb : blk_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q <= '0;
            zacc_q <= '0;
            par_q  <= 1'b0;
        end else if (frame_stb) begin
            par_q  <= ~par_q;
            fcnt_q <= blk_end ? '0 : fcnt_q + CW'(1);
            zacc_q <= blk_end ? '0 : ztot;
        end
    end

    // R8: align marks never fall on two frames in a row
    a_r8_align_alternates: assert property (@(posedge clk) disable iff (rst)
        align_o |=> !align_o);

    // R7: without CRC-4 the mark only comes from a frame
    a_r7_mf_needs_frame: assert property (@(posedge clk) disable iff (rst)
        (!crc4_en && !frame_stb) |-> !mf_o);

endmodule

// File: rtl/e1_ts16_zero.sv
module e1_ts16_zero #(
    parameter int SIG_FRAMES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic       mf_first,
    input  logic [7:0] ts16,
    output logic       zeros_o
);
    localparam int RW = $clog2(SIG_FRAMES + 1);

    logic [RW-1:0] run_q;
    logic [RW-1:0] run_nx;
    logic          is_zero;

    assign is_zero = (ts16 == 8'h00);

    always_comb begin
        if (mf_first)                    run_nx = is_zero ? RW'(1) : '0;
        else if (run_q != '0 && is_zero) run_nx = run_q + RW'(1);
        else                             run_nx = '0;
    end

    assign zeros_o = frame_stb && (run_nx == RW'(SIG_FRAMES));

    always_ff @(posedge clk) begin
        if (rst)            run_q <= '0;
        else if (frame_stb) run_q <= zeros_o ? '0 : run_nx;
    end

    // R6: a non-zero slot byte breaks the run
    a_r6_nonzero_breaks_run: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !is_zero) |=> (run_q == '0));

endmodule

// File: rtl/e1_status_latch.sv
module e1_status_latch
    import e1_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  evt_t                ev_i,
    input  logic                clr_we,
    input  logic [STATUS_W-1:0] clr_bits,
    input  logic [IRQ_SRC-1:0]  irq_en,
    output logic [STATUS_W-1:0] status_o,
    output logic                irq_o
);
    logic [EVT_W-1:0] q;
    logic [EVT_W-1:0] ev_v;
    logic [EVT_W-1:0] clr_v;

    assign ev_v     = ev_i;
    assign clr_v    = clr_we ? clr_bits[EVT_W-1:0] : '0;
    assign status_o = {{(STATUS_W-EVT_W){1'b0}}, q};
    assign irq_o    = |(q[IRQ_SRC-1:0] & irq_en);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_v) | ev_v;
    end

    // R9: an event is latched even when a clear arrives with it
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_v != '0) |=> ((q & $past(ev_v)) == $past(ev_v)));

    // R9: a clear without events removes the selected bits
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_we && ev_v == '0) |=> ((q & $past(clr_bits[EVT_W-1:0])) == '0));

    // R10: with every enable off there is no interrupt
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq_o);

endmodule

// File: rtl/e1_rx_event_latch.sv
module e1_rx_event_latch
    import e1_evt_pkg::*;
#(
    parameter int CRC_BLOCK  = 1000,
    parameter int CRC_THRESH = 915,
    parameter int FAS_RUN    = 3,
    parameter int CAS_RUN    = 2,
    parameter int SIG_FRAMES = 16,
    parameter int ONES_LIMIT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_stb,
    input  logic [7:0]          ts16_byte,
    input  logic                sig_mf_first,
    input  logic                crc_mf_stb,
    input  logic                fas_stb,
    input  logic                fas_bad,
    input  logic                cas_stb,
    input  logic                cas_bad,
    input  logic                crc_stb,
    input  logic                crc_bad,
    input  logic                crc4_en,
    input  logic                clr_we,
    input  logic [STATUS_W-1:0] clr_bits,
    input  logic [IRQ_SRC-1:0]  irq_en,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);
    evt_t ev;

    e1_err_run #(.RUN_LEN(FAS_RUN)) u_fas_run (
        .clk(clk), .rst(rst), .stb_i(fas_stb), .bad_i(fas_bad),
        .evt_o(ev.fas_resync)
    );

    e1_err_run #(.RUN_LEN(CAS_RUN)) u_cas_run (
        .clk(clk), .rst(rst), .stb_i(cas_stb), .bad_i(cas_bad),
        .evt_o(ev.cas_resync)
    );

    e1_crc_window #(.BLOCK(CRC_BLOCK), .THRESH(CRC_THRESH)) u_crc_win (
        .clk(clk), .rst(rst), .stb_i(crc_stb), .bad_i(crc_bad),
        .evt_o(ev.crc_resync)
    );

    e1_frame_timing #(.SIG_FRAMES(SIG_FRAMES), .ONES_LIMIT(ONES_LIMIT)) u_timing (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .ts16(ts16_byte),
        .crc4_en(crc4_en), .crc_mf_stb(crc_mf_stb),
        .align_o(ev.align_mark), .mf_o(ev.mf_mark), .ones_o(ev.sig_ones)
    );

    e1_ts16_zero #(.SIG_FRAMES(SIG_FRAMES)) u_zero (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mf_first(sig_mf_first),
        .ts16(ts16_byte), .zeros_o(ev.sig_zeros)
    );

    e1_status_latch u_latch (
        .clk(clk), .rst(rst), .ev_i(ev), .clr_we(clr_we), .clr_bits(clr_bits),
        .irq_en(irq_en), .status_o(status), .irq_o(irq)
    );

endmodule

// File: tb/e1_rx_event_latch_bench.sv
module e1_rx_event_latch_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 0, sig_mf_first = 0, crc_mf_stb = 0;
    logic [7:0] ts16_byte = 8'hFF;
    logic       fas_stb = 0, fas_bad = 0, cas_stb = 0, cas_bad = 0;
    logic       crc_stb = 0, crc_bad = 0, crc4_en = 0, clr_we = 0;
    logic [7:0] clr_bits = 8'h00;
    logic [3:0] irq_en = 4'h0;
    logic [7:0] status;
    logic       irq;

    int vectors = 0;
    int fails   = 0;
    int frames_sent = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    e1_rx_event_latch u_e1_rx_event_latch (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .ts16_byte(ts16_byte),
        .sig_mf_first(sig_mf_first), .crc_mf_stb(crc_mf_stb),
        .fas_stb(fas_stb), .fas_bad(fas_bad), .cas_stb(cas_stb), .cas_bad(cas_bad),
        .crc_stb(crc_stb), .crc_bad(crc_bad), .crc4_en(crc4_en),
        .clr_we(clr_we), .clr_bits(clr_bits), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int  m_fas, m_cas, m_crc_idx, m_crc_err, m_fcnt, m_zacc, m_zrun;
    bit  m_par;
    logic [7:0] m_status;

    function automatic int zeros_in(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (b[i] == 1'b0) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        logic [7:0] ev;
        ev = 8'h00;
        if (rst) begin
            m_fas = 0; m_cas = 0; m_crc_idx = 0; m_crc_err = 0;
            m_fcnt = 0; m_zacc = 0; m_zrun = 0; m_par = 0; m_status = 8'h00;
        end else begin
            if (fas_stb) begin
                if (!fas_bad) m_fas = 0;
                else begin m_fas++; if (m_fas == 3) begin ev[4] = 1; m_fas = 0; end end
            end
            if (cas_stb) begin
                if (!cas_bad) m_cas = 0;
                else begin m_cas++; if (m_cas == 2) begin ev[5] = 1; m_cas = 0; end end
            end
            if (crc_stb) begin
                m_crc_idx++;
                if (crc_bad) m_crc_err++;
                if (m_crc_idx == 1000) begin
                    if (m_crc_err >= 915) ev[6] = 1;
                    m_crc_idx = 0; m_crc_err = 0;
                end
            end
            if (crc4_en && crc_mf_stb) ev[1] = 1;
            if (frame_stb) begin
                if (m_par) ev[0] = 1;
                m_par = !m_par;
                m_zacc += zeros_in(ts16_byte);
                m_fcnt++;
                if (m_fcnt == 16) begin
                    if (m_zacc < 3) ev[3] = 1;
                    if (!crc4_en) ev[1] = 1;
                    m_fcnt = 0; m_zacc = 0;
                end
                if (sig_mf_first) m_zrun = (ts16_byte == 0) ? 1 : 0;
                else if (m_zrun > 0 && ts16_byte == 0) m_zrun++;
                else m_zrun = 0;
                if (m_zrun == 16) begin ev[2] = 1; m_zrun = 0; end
            end
            m_status = (m_status & ~(clr_we ? (clr_bits & 8'h7F) : 8'h00)) | ev;
        end
    end

    function automatic string req_of_bit(input int b);
        case (b)
            0: return "R8"; 1: return "R7"; 2: return "R6"; 3: return "R5";
            4: return "R2"; 5: return "R3"; 6: return "R4"; default: return "R9";
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (status !== m_status) begin
                int b = 0;
                for (int i = 7; i >= 0; i--) if (status[i] !== m_status[i]) b = i;
                fails++;
                $display("FAIL %s model status act=%02h exp=%02h", req_of_bit(b), status, m_status);
            end
            vectors++;
            if (irq !== |(m_status[3:0] & irq_en)) begin
                fails++;
                $display("FAIL R10 model irq act=%0b exp=%0b", irq, |(m_status[3:0] & irq_en));
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input int b, input bit exp, input string req);
        chk(status[b] === exp, req, status[b], exp);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_we = 1; clr_bits = 8'hFF;
        @(negedge clk); clr_we = 0; clr_bits = 8'h00;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit first);
        @(negedge clk); frame_stb = 1; ts16_byte = b; sig_mf_first = first;
        @(negedge clk); frame_stb = 0; sig_mf_first = 0; ts16_byte = 8'hFF;
        frames_sent++;
    endtask

    task automatic pad_block();
        while (frames_sent % 16 != 0) send_frame(8'hFF, 0);
    endtask

    task automatic fas_word(input bit bad);
        @(negedge clk); fas_stb = 1; fas_bad = bad;
        @(negedge clk); fas_stb = 0; fas_bad = 0;
    endtask

    task automatic cas_word(input bit bad);
        @(negedge clk); cas_stb = 1; cas_bad = bad;
        @(negedge clk); cas_stb = 0; cas_bad = 0;
    endtask

    task automatic crc_word(input bit bad);
        @(negedge clk); crc_stb = 1; crc_bad = bad;
        @(negedge clk); crc_stb = 0; crc_bad = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog expired act=1 exp=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(status === 8'h00, "R1 status", status, 0);
        chk(irq === 1'b0, "R1 irq", irq, 0);

        // R2: broken run, then full run of three
        fas_word(1); fas_word(1); fas_word(0); fas_word(1); fas_word(1);
        chk_bit(4, 0, "R2 two after good");
        fas_word(1);
        chk_bit(4, 1, "R2 third in row");

        // R3
        clear_all();
        cas_word(1); cas_word(0); cas_word(1);
        chk_bit(5, 0, "R3 broken run");
        cas_word(1);
        chk_bit(5, 1, "R3 second in row");

        // R4: 914 errors, then 915 errors
        clear_all();
        for (int i = 0; i < 1000; i++) crc_word(i < 914);
        chk_bit(6, 0, "R4 914 errors");
        for (int i = 0; i < 999; i++) crc_word(i < 915);
        chk_bit(6, 0, "R4 before block end");
        crc_word(0);
        chk_bit(6, 1, "R4 915 errors");

        // R5 and R7 (crc4 off)
        pad_block(); clear_all();
        send_frame(8'hFC, 0);
        for (int i = 0; i < 15; i++) send_frame(8'hFF, 0);
        chk_bit(3, 1, "R5 two zeros");
        chk_bit(1, 1, "R7 block mark crc4 off");
        clear_all();
        send_frame(8'hF8, 0);
        for (int i = 0; i < 15; i++) send_frame(8'hFF, 0);
        chk_bit(3, 0, "R5 three zeros");
        // R7: pulse ignored with crc4 off
        clear_all();
        @(negedge clk); crc_mf_stb = 1; @(negedge clk); crc_mf_stb = 0;
        chk_bit(1, 0, "R7 pulse ignored");

        // R6
        clear_all();
        send_frame(8'h00, 1);
        for (int i = 0; i < 15; i++) send_frame(8'h00, 0);
        chk_bit(2, 1, "R6 full zero mf");
        clear_all();
        send_frame(8'h00, 1);
        for (int i = 0; i < 14; i++) send_frame(8'h00, 0);
        send_frame(8'h01, 0);
        chk_bit(2, 0, "R6 one nonzero");
        for (int i = 0; i < 16; i++) send_frame(8'h00, 0);
        chk_bit(2, 0, "R6 no start flag");

        // R8
        if (frames_sent % 2 != 0) send_frame(8'hFF, 0);
        clear_all();
        send_frame(8'hFF, 0);
        chk_bit(0, 0, "R8 odd frame");
        send_frame(8'hFF, 0);
        chk_bit(0, 1, "R8 even frame");

        // R7 with crc4 on
        crc4_en = 1;
        pad_block(); clear_all();
        for (int i = 0; i < 16; i++) send_frame(8'hFF, 0);
        chk_bit(1, 0, "R7 no frame mark crc4 on");
        @(negedge clk); crc_mf_stb = 1; @(negedge clk); crc_mf_stb = 0;
        chk_bit(1, 1, "R7 pulse crc4 on");
        crc4_en = 0;

        // R9: set wins over a same-cycle clear, bit 7 stays 0
        clear_all();
        fas_word(1); fas_word(1);
        @(negedge clk); fas_stb = 1; fas_bad = 1; clr_we = 1; clr_bits = 8'hFF;
        @(negedge clk); fas_stb = 0; fas_bad = 0; clr_we = 0; clr_bits = 8'h00;
        chk_bit(4, 1, "R9 set wins");
        chk_bit(7, 0, "R9 bit7 zero");
        @(negedge clk); clr_we = 1; clr_bits = 8'h10;
        @(negedge clk); clr_we = 0; clr_bits = 8'h00;
        chk_bit(4, 0, "R9 clear");

        // R10
        irq_en = 4'hF;
        cas_word(1); cas_word(1);
        chk(irq === 1'b0, "R10 high bits no irq", irq, 0);
        irq_en = 4'h0;
        if (frames_sent % 2 == 0) send_frame(8'hFF, 0);
        send_frame(8'hFF, 0);
        chk(irq === 1'b0, "R10 masked", irq, 0);
        irq_en = 4'h1;
        @(negedge clk);
        chk(irq === 1'b1, "R10 enabled", irq, 1);
        irq_en = 4'h2;
        @(negedge clk);
        chk(irq === 1'b0, "R10 other enable", irq, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule